// File: doc/BRIEF.md
# Two-Bank Programmable Logic Fabric

This block is a small reconfigurable logic fabric with sixteen logic cells split evenly into two banks. Every cell evaluates an arbitrary two-input Boolean function from a four-bit truth table. Every cell also holds a flip-flop that samples that function on each clock edge, and a per-cell bit picks which of the two values the cell presents. The inputs of each cell come from two source selectors. A selector can pick an external input, the flip-flop of any cell in the same bank, or a constant zero.

The two banks are coupled by one fixed path in each direction. On the first cell of each bank, selector A code 0 taps the flip-flop of the last cell of the other bank in place of external input 0. A single write port loads the per-cell configuration words and one routing word. The routing word steers one cell onto an interrupt line and another onto a conversion-start pulse. All sixteen cell outputs can be read as one word, and the lower fourteen drive the external outputs.

Top module: `pla_fabric`

## Requirements
- R1: A synchronous active-high reset clears every cell configuration, every cell flip-flop, the routing word and the edge history. In the first cycle after reset is released, `rd_value`, `ext_out`, `irq` and `conv_start` are all zero.
- R2: A cell in combinational mode outputs bit {A,B} of its truth table, with A as the upper index bit, so that bit 2*A+B is selected.
- R3: A cell with its registered-mode bit set outputs the truth-table result that was present during the previous clock cycle.
- R4: Selector codes 0 to 15 pick `ext_in[code]`. Codes 16 to 23 pick the flip-flop of cell (code-16) of the same bank, whatever that cell's output mode. Codes 24 to 31 give constant 0.
- R5: On cell 0 of bank 0, selector A code 0 gives the flip-flop of cell 7 of bank 1. On cell 0 of bank 1, selector A code 0 gives the flip-flop of cell 7 of bank 0. Code 0 on every other selector still picks `ext_in[0]`.
- R6: A write with `cfg_we` high and address 0 to 15 loads cell address (bank*8+cell) and takes effect in the next cycle. The cell word is {registered[14], selB[13:9], selA[8:4], truth[3:0]}. Address 16 loads the routing word. Writes to addresses 17 to 31 change nothing.
- R7: `rd_value[k]` is the output of cell k for k = 0 to 15, and `ext_out[k]` equals the output of cell k for k = 0 to 13.
- R8: The routing word is {conv_en[9], conv_sel[8:5], irq_en[4], irq_sel[3:0]}. `irq` equals irq_en AND the output of cell irq_sel.
- R9: When conv_en is set, `conv_start` is high for exactly the cycle in which the output of cell conv_sel is 1 after being 0 in the previous cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Fabric clock |
| rst | input | 1 | Synchronous active-high reset |
| ext_in | input | 16 | External inputs; bit 15 carries the comparator result |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_addr | input | 5 | Configuration address (0-15 cells, 16 routing) |
| cfg_data | input | 15 | Configuration word |
| ext_out | output | 14 | Outputs of cells 0 to 13 |
| irq | output | 1 | Interrupt request from the routed cell |
| conv_start | output | 1 | One-cycle conversion-start pulse |
| rd_value | output | 16 | Outputs of all sixteen cells |

## Verification
The assertions check the following on every cycle: every flip-flop holds the previous cycle's lookup result, the outputs are all zero on the first cycle after reset, `irq` never rises while every cell output is low, and a conversion pulse never lasts two cycles while the routing stays unchanged. The bench scenarios are the only checks of the truth-table indexing, the meaning of each selector code, and the cross-bank feedback replacing `ext_in[0]` on the first cells only. They also show that writes to unused addresses leave the fabric untouched.

// File: rtl/pla_pkg.sv
package pla_pkg;
    localparam int BANKS      = 2;
    localparam int ELEMS      = 8;
    localparam int TOTAL      = BANKS * ELEMS;
    localparam int IN_W       = 16;
    localparam int OUT_W      = 14;
    localparam int SRC_N      = 32;
    localparam int SEL_W      = $clog2(SRC_N);
    localparam int IDX_W      = $clog2(TOTAL);
    localparam int ADDR_W     = 5;
    localparam int LUT_W      = 4;
    localparam logic [ADDR_W-1:0] ROUTE_ADDR = ADDR_W'(TOTAL);

    typedef struct packed {
        logic             registered;
        logic [SEL_W-1:0] sel_b;
        logic [SEL_W-1:0] sel_a;
        logic [LUT_W-1:0] truth;
    } cell_cfg_t;

    typedef struct packed {
        logic             conv_en;
        logic [IDX_W-1:0] conv_sel;
        logic             irq_en;
        logic [IDX_W-1:0] irq_sel;
    } route_cfg_t;

    localparam int CFG_W   = $bits(cell_cfg_t);
    localparam int ROUTE_W = $bits(route_cfg_t);

    function automatic logic lut_eval(input logic [LUT_W-1:0] truth,
                                      input logic a, input logic b);
        return truth[{a, b}];
    endfunction
endpackage

// File: rtl/pla_cell.sv
module pla_cell
    import pla_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  cell_cfg_t        cfg,
    input  logic [SRC_N-1:0] src_a,
    input  logic [SRC_N-1:0] src_b,
    output logic             lut_o,
    output logic             ff_q,
    output logic             cell_o
);
    logic in_a;
    logic in_b;

    always_comb begin
        in_a   = src_a[cfg.sel_a];
        in_b   = src_b[cfg.sel_b];
        lut_o  = lut_eval(cfg.truth, in_a, in_b);
        cell_o = cfg.registered ? ff_q : lut_o;
    end

    always_ff @(posedge clk) begin
        if (rst) ff_q <= 1'b0;
        else     ff_q <= lut_o;
    end
endmodule

// File: rtl/pla_bank.sv
module pla_bank
    import pla_pkg::*;
#(
    parameter int N = ELEMS
) (
    input  logic                clk,
    input  logic                rst,
    input  logic [IN_W-1:0]     ext_in,
    input  logic                xfb,
    input  cell_cfg_t [N-1:0]   cfg,
    output logic [N-1:0]        lut_o,
    output logic [N-1:0]        ff_q,
    output logic [N-1:0]        cell_o
);
    localparam int PAD = SRC_N - IN_W - N;

    logic [SRC_N-1:0] src_common;
    assign src_common = {{PAD{1'b0}}, ff_q, ext_in};

    for (genvar e = 0; e < N; e++) begin : g_cell
        logic [SRC_N-1:0] src_a;
        if (e == 0) begin : g_xfb
            assign src_a = {src_common[SRC_N-1:1], xfb};
        end else begin : g_local
            assign src_a = src_common;
        end

        pla_cell u_cell (
            .clk    (clk),
            .rst    (rst),
            .cfg    (cfg[e]),
            .src_a  (src_a),
            .src_b  (src_common),
            .lut_o  (lut_o[e]),
            .ff_q   (ff_q[e]),
            .cell_o (cell_o[e])
        );
    end
endmodule

// File: rtl/pla_cfg_regs.sv
module pla_cfg_regs
    import pla_pkg::*;
(
    input  logic                  clk,
    input  logic                  rst,
    input  logic                  cfg_we,
    input  logic [ADDR_W-1:0]     cfg_addr,
    input  logic [CFG_W-1:0]      cfg_data,
    output cell_cfg_t [TOTAL-1:0] ccfg,
    output route_cfg_t            rcfg
);
    for (genvar k = 0; k < TOTAL; k++) begin : g_reg
        logic hit;
        assign hit = cfg_we && (cfg_addr == ADDR_W'(k));
        always_ff @(posedge clk) begin
            if (rst)      ccfg[k] <= '0;
            else if (hit) ccfg[k] <= cell_cfg_t'(cfg_data);
        end
    end

    always_ff @(posedge clk) begin
        if (rst)
            rcfg <= '0;
        else if (cfg_we && cfg_addr == ROUTE_ADDR)
            rcfg <= route_cfg_t'(cfg_data[ROUTE_W-1:0]);
    end
endmodule

// File: rtl/pla_route.sv
module pla_route
    import pla_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  route_cfg_t       rcfg,
    input  logic [TOTAL-1:0] cell_o,
    output logic             irq,
    output logic             conv_start
);
    logic conv_cur;
    logic conv_prev;

    always_comb begin
        conv_cur   = cell_o[rcfg.conv_sel];
        irq        = rcfg.irq_en & cell_o[rcfg.irq_sel];
        conv_start = rcfg.conv_en & conv_cur & ~conv_prev;
    end

    always_ff @(posedge clk) begin
        if (rst) conv_prev <= 1'b0;
        else     conv_prev <= conv_cur;
    end
endmodule

// File: rtl/pla_fabric.sv
module pla_fabric
    import pla_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic [IN_W-1:0]   ext_in,
    input  logic              cfg_we,
    input  logic [ADDR_W-1:0] cfg_addr,
    input  logic [CFG_W-1:0]  cfg_data,
    output logic [OUT_W-1:0]  ext_out,
    output logic              irq,
    output logic              conv_start,
    output logic [TOTAL-1:0]  rd_value
);
    cell_cfg_t [TOTAL-1:0] ccfg;
    route_cfg_t            rcfg;
    logic [TOTAL-1:0]      lut_all;
    logic [TOTAL-1:0]      ff_all;
    logic [TOTAL-1:0]      cell_all;

    pla_cfg_regs u_cfg (
        .clk      (clk),
        .rst      (rst),
        .cfg_we   (cfg_we),
        .cfg_addr (cfg_addr),
        .cfg_data (cfg_data),
        .ccfg     (ccfg),
        .rcfg     (rcfg)
    );

    for (genvar b = 0; b < BANKS; b++) begin : g_bank
        localparam int OTHER = (b + 1) % BANKS;
        pla_bank #(.N(ELEMS)) u_bank (
            .clk    (clk),
            .rst    (rst),
            .ext_in (ext_in),
            .xfb    (ff_all[OTHER*ELEMS + ELEMS - 1]),
            .cfg    (ccfg[b*ELEMS +: ELEMS]),
            .lut_o  (lut_all[b*ELEMS +: ELEMS]),
            .ff_q   (ff_all[b*ELEMS +: ELEMS]),
            .cell_o (cell_all[b*ELEMS +: ELEMS])
        );
    end

    pla_route u_route (
        .clk        (clk),
        .rst        (rst),
        .rcfg       (rcfg),
        .cell_o     (cell_all),
        .irq        (irq),
        .conv_start (conv_start)
    );

    assign rd_value = cell_all;
    assign ext_out  = cell_all[OUT_W-1:0];
endmodule

// File: rtl/pla_fabric_chk.sv
module pla_fabric_chk
    import pla_pkg::*;
(
    input logic             clk,
    input logic             rst,
    input logic             cfg_we,
    input logic [OUT_W-1:0] ext_out,
    input logic             irq,
    input logic             conv_start,
    input logic [TOTAL-1:0] rd_value,
    input logic [TOTAL-1:0] lut_all,
    input logic [TOTAL-1:0] ff_all
);
    assert_reset_clear_R1: assert property (@(posedge clk) disable iff (rst)
        $fell(rst) |-> (rd_value == '0 && ext_out == '0 && !irq && !conv_start));

    assert_ff_capture_R3: assert property (@(posedge clk) disable iff (rst)
        !rst |=> (ff_all == $past(lut_all)));

    assert_irq_source_R8: assert property (@(posedge clk) disable iff (rst)
        irq |-> (rd_value != '0));

    assert_conv_single_R9: assert property (@(posedge clk) disable iff (rst)
        (conv_start && !cfg_we) |=> !conv_start);

    assert_conv_source_R9: assert property (@(posedge clk) disable iff (rst)
        conv_start |-> (rd_value != '0));
endmodule

bind pla_fabric pla_fabric_chk u_chk (
    .clk        (clk),
    .rst        (rst),
    .cfg_we     (cfg_we),
    .ext_out    (ext_out),
    .irq        (irq),
    .conv_start (conv_start),
    .rd_value   (rd_value),
    .lut_all    (lut_all),
    .ff_all     (ff_all)
);

// File: tb/sim_pla_fabric.sv
module sim_pla_fabric;
    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [15:0] ext_in = '1;
    logic        cfg_we = 1'b0;
    logic [4:0]  cfg_addr = '0;
    logic [14:0] cfg_data = '0;
    logic [13:0] ext_out;
    logic        irq;
    logic        conv_start;
    logic [15:0] rd_value;

    int n_checks = 0;
    int n_fail   = 0;
    bit finished = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    pla_fabric u0 (
        .clk(clk), .rst(rst), .ext_in(ext_in), .cfg_we(cfg_we),
        .cfg_addr(cfg_addr), .cfg_data(cfg_data), .ext_out(ext_out),
        .irq(irq), .conv_start(conv_start), .rd_value(rd_value)
    );

    // {truth[3:0], A, B, expected}
    localparam logic [6:0] VEC [0:9] = '{
        7'b1000_1_1_1, 7'b1000_1_0_0,
        7'b0110_1_0_1, 7'b0110_1_1_0,
        7'b1110_0_0_0, 7'b1110_0_1_1,
        7'b0001_0_0_1, 7'b0001_1_0_0,
        7'b0100_1_0_1, 7'b0100_0_1_0
    };

    function automatic logic [14:0] mk(input logic [3:0] t, input logic [4:0] sa,
                                       input logic [4:0] sb, input logic r);
        return {r, sb, sa, t};
    endfunction

    function automatic logic [14:0] mk_route(input logic ce, input logic [3:0] cs,
                                             input logic ie, input logic [3:0] is);
        return {5'b0, ce, cs, ie, is};
    endfunction

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
        end
    endtask

    task automatic write_cfg(input logic [4:0] a, input logic [14:0] d);
        @(negedge clk);
        cfg_we = 1'b1; cfg_addr = a; cfg_data = d;
        @(negedge clk);
        cfg_we = 1'b0;
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst = 1'b1; cfg_we = 1'b0; ext_in = '0;
        repeat (2) @(negedge clk);
        rst = 1'b0;
    endtask

    task automatic finish_run();
        if (!finished) begin
            finished = 1;
            $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
            $finish;
        end
    endtask

    initial begin
        #(CLK_PERIOD * 100000);
        n_checks++;
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_run();
    end

    initial begin
        logic [15:0] snap;
        // R1: reset with inputs driven high
        repeat (2) @(negedge clk);
        ext_in = '1;
        rst = 1'b0;
        #1;
        check("R1 rd_value after reset", rd_value, 0);
        check("R1 ext_out after reset", ext_out, 0);
        check("R1 irq after reset", irq, 0);
        check("R1 conv_start after reset", conv_start, 0);

        // R2/R7: truth-table vectors on cell 1, A=ext_in[1], B=ext_in[2]
        for (int i = 0; i < 10; i++) begin
            write_cfg(5'd1, mk(VEC[i][6:3], 5'd1, 5'd2, 1'b0));
            ext_in = '0;
            ext_in[1] = VEC[i][2];
            ext_in[2] = VEC[i][1];
            #1;
            check("R2 lut output", rd_value[1], VEC[i][0]);
            check("R7 ext_out mirror", ext_out[1], VEC[i][0]);
        end

        // R1: configured cell cleared by reset
        write_cfg(5'd3, mk(4'b1111, 5'd24, 5'd24, 1'b0));
        #1;
        check("R1 const-one cell before reset", rd_value[3], 1);
        do_reset();
        #1;
        check("R1 config cleared", rd_value, 0);

        // R3: registered cell 2 buffers ext_in[4]
        write_cfg(5'd2, mk(4'b1100, 5'd4, 5'd24, 1'b1));
        ext_in[4] = 1'b1;
        #1;
        check("R3 registered holds old", rd_value[2], 0);
        @(negedge clk); #1;
        check("R3 registered updates", rd_value[2], 1);
        ext_in[4] = 1'b0;
        #1;
        check("R3 registered delays fall", rd_value[2], 1);
        @(negedge clk); #1;
        check("R3 registered falls", rd_value[2], 0);

        // R4: cell 4 reads cell 2 flip-flop (code 18)
        write_cfg(5'd4, mk(4'b1100, 5'd18, 5'd24, 1'b0));
        ext_in[4] = 1'b1;
        #1;
        check("R4 same-bank tap before edge", rd_value[4], 0);
        @(negedge clk); #1;
        check("R4 same-bank tap after edge", rd_value[4], 1);
        write_cfg(5'd5, mk(4'b0011, 5'd24, 5'd24, 1'b0));
        write_cfg(5'd6, mk(4'b1100, 5'd30, 5'd24, 1'b0));
        ext_in = '1;
        #1;
        check("R4 code 24 is zero", rd_value[5], 1);
        check("R4 code 30 is zero", rd_value[6], 0);

        // R8: interrupt routing (cell 5 = 1, cell 6 = 0)
        write_cfg(5'd16, mk_route(1'b0, 4'd0, 1'b1, 4'd5));
        #1;
        check("R8 irq from cell 5", irq, 1);
        write_cfg(5'd16, mk_route(1'b0, 4'd0, 1'b1, 4'd6));
        #1;
        check("R8 irq from cell 6", irq, 0);
        write_cfg(5'd16, mk_route(1'b0, 4'd0, 1'b0, 4'd5));
        #1;
        check("R8 irq disabled", irq, 0);

        // R6: unused addresses change nothing
        write_cfg(5'd16, mk_route(1'b0, 4'd0, 1'b1, 4'd5));
        @(negedge clk); #1;
        snap = rd_value;
        write_cfg(5'd20, 15'h7FFF);
        write_cfg(5'd17, 15'h7FFF);
        write_cfg(5'd31, 15'h0000);
        #1;
        check("R6 unused address rd_value", rd_value, snap);
        check("R6 unused address irq", irq, 1);

        // R5: cross-bank feedback
        do_reset();
        write_cfg(5'd8,  mk(4'b1100, 5'd0, 5'd24, 1'b0));
        write_cfg(5'd7,  mk(4'b1100, 5'd6, 5'd24, 1'b0));
        write_cfg(5'd9,  mk(4'b1100, 5'd0, 5'd24, 1'b0));
        write_cfg(5'd0,  mk(4'b1100, 5'd0, 5'd24, 1'b0));
        write_cfg(5'd15, mk(4'b1100, 5'd7, 5'd24, 1'b0));
        ext_in = '0;
        ext_in[6] = 1'b1;
        repeat (2) @(negedge clk);
        #1;
        check("R5 bank1 cell0 follows bank0 cell7", rd_value[8], 1);
        check("R5 bank1 cell1 code0 is ext_in0", rd_value[9], 0);
        check("R5 bank0 cell0 follows bank1 cell15", rd_value[0], 0);
        ext_in = '0;
        ext_in[0] = 1'b1;
        ext_in[7] = 1'b1;
        #1;
        check("R5 cell9 follows ext_in0 at once", rd_value[9], 1);
        check("R5 cell8 holds until edge", rd_value[8], 1);
        @(negedge clk); #1;
        check("R5 cell8 after edge", rd_value[8], 0);
        check("R5 cell0 after edge", rd_value[0], 1);

        // R9: conversion-start pulse from cell 11 (ext_in[9])
        do_reset();
        write_cfg(5'd11, mk(4'b1100, 5'd9, 5'd24, 1'b0));
        write_cfg(5'd16, mk_route(1'b1, 4'd11, 1'b0, 4'd0));
        #1;
        check("R9 no pulse while low", conv_start, 0);
        ext_in[9] = 1'b1;
        #1;
        check("R9 pulse on rise", conv_start, 1);
        @(negedge clk); #1;
        check("R9 pulse one cycle", conv_start, 0);
        ext_in[9] = 1'b0;
        #1;
        check("R9 no pulse on fall", conv_start, 0);
        @(negedge clk);
        ext_in[9] = 1'b1;
        #1;
        check("R9 second pulse", conv_start, 1);

        finish_run();
    end
endmodule